// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vectorised load or store request into a stream of per-element effective addresses. A request carries a scalar base value (or an "RA field is zero" flag that forces the base to zero), a 16-bit signed displacement, the element access size in bytes, a vector length, a stride mode and a shift amount. After accepting a request the sequencer emits one address per element over a valid/ready handshake, in element order or in bit-reversed order depending on the mode.

For the two base-update modes the block also returns the updated base value for register write-back, presented alongside the final element. The memory access, register-file reads and writes, predication and higher-level remapping schedules sit outside this block.

Top module: `vls_agen`

## Requirements
- R1: Mode code 0 (unit stride): element i uses address base + sext(D) + size*i.
- R2: Mode code 1 (element stride): element i uses address base + sext(D)*i; when D is zero the request behaves exactly as unit stride.
- R3: When the RA-zero flag is set, the base is taken as 0 and the supplied base value is ignored.
- R4: Mode code 2 (post-increment update): each element uses the running base as its address, the base then advances by sext(D); the write-back value is start + VL*sext(D).
- R5: Mode code 3 (pre-update): the running base is advanced by sext(D) first and that sum is the element address; the write-back value equals the last element address.
- R6: Mode code 4 (bit-reversed): element i uses base + ((sext(D)*size*rev(i)) << shift), where rev reverses i over L bits and L is the smallest value with 2^L >= VL; for VL=4 the visited offsets run 0,2,1,3.
- R7: Addresses are 64 bits and wrap modulo 2^64; D is a 16-bit two's-complement immediate sign-extended before use.
- R8: A request with VL of zero produces no address, no write-back, and leaves the block idle.
- R9: in_ready is high only while the block is idle; a request presented while busy is ignored.
- R10: The first address appears the cycle after acceptance with out_idx 0; while out_valid is high and out_ready is low, out_addr and out_idx hold; each accepted element advances out_idx by one.
- R11: out_done is high exactly with the last element; wb_en is high only then and only in modes 2 and 3; the block is idle after the last element is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_mode | input | 3 | Stride mode code (0..4) |
| in_ra_zero | input | 1 | Base register field is zero: use 0 as base |
| in_ra_val | input | AW (64) | Base register value |
| in_disp | input | DW (16) | Signed displacement |
| in_size | input | SZW (4) | Element access size in bytes |
| in_vl | input | VLW (7) | Vector length |
| in_shift | input | SHW (3) | Left shift for bit-reversed mode |
| out_valid | output | 1 | Element address valid |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | AW (64) | Element effective address |
| out_idx | output | VLW (7) | Sequential element number |
| out_done | output | 1 | Current element is the last |
| wb_en | output | 1 | Updated base valid for write-back |
| wb_base | output | AW (64) | Updated base value |

## Verification
The bench builds the block with its defaults: 64-bit addresses, 16-bit displacement, a 7-bit vector length and a 3-bit shift. The 64-bit width lets negative displacements and a base near the top of the address space show wraparound, and the 7-bit length lets bit reversal run over up to three index bits at VL=8 with a non-zero shift, besides the VL=4 order 0,2,1,3. Backpressure and a request presented mid-sequence exercise the hold and ignore rules.

// File: rtl/vls_agen_pkg.sv
package vls_agen_pkg;

  typedef enum logic [2:0] {
    M_UNIT = 3'd0,
    M_ELEM = 3'd1,
    M_POST = 3'd2,
    M_UPD  = 3'd3,
    M_BREV = 3'd4
  } agen_mode_e;

  // smallest L such that 2**L >= vl
  function automatic int unsigned f_levels(input int unsigned vl);
    int unsigned lv;
    lv = 0;
    for (int k = 31; k >= 0; k--) begin
      if (vl <= (32'd1 << k)) lv = k;
    end
    return lv;
  endfunction

  function automatic logic f_is_update(input agen_mode_e m);
    return (m == M_POST) || (m == M_UPD);
  endfunction

endpackage

// File: rtl/vls_agen_idx.sv
module vls_agen_idx #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [VLW-1:0] vl,
  output logic [VLW-1:0] idx,
  output logic           is_last
);
  logic [VLW-1:0] vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      vl_q <= '0;
    end else if (load) begin
      idx  <= '0;
      vl_q <= vl;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end

  assign is_last = (idx + 1'b1) == vl_q;
endmodule

// File: rtl/vls_agen_base.sv
module vls_agen_base #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [AW-1:0] delta,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  assign nxt = cur + delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= '0;
    else if (load)  cur <= load_val;
    else if (step)  cur <= nxt;
  end
endmodule

// File: rtl/vls_agen_calc.sv
module vls_agen_calc
  import vls_agen_pkg::*;
#(
  parameter int AW  = 64,
  parameter int SZW = 4,
  parameter int VLW = 7,
  parameter int SHW = 3,
  localparam int LVW = $clog2(VLW + 1)
) (
  input  agen_mode_e     mode,
  input  logic [AW-1:0]  base0,
  input  logic [AW-1:0]  run_base,
  input  logic [AW-1:0]  run_next,
  input  logic [AW-1:0]  disp,
  input  logic [SZW-1:0] size,
  input  logic [VLW-1:0] idx,
  input  logic [LVW-1:0] levels,
  input  logic [SHW-1:0] shift,
  output logic [AW-1:0]  addr,
  output logic [VLW-1:0] rev_idx
);
  logic [VLW-1:0] rev_full;
  logic [LVW-1:0] rsh;

  for (genvar b = 0; b < VLW; b++) begin : g_rev
    assign rev_full[b] = idx[VLW-1-b];
  end

  assign rsh     = LVW'(VLW) - levels;
  assign rev_idx = rev_full >> rsh;

  function automatic logic [AW-1:0] f_unit(input logic [AW-1:0] b,
      input logic [AW-1:0] d, input logic [SZW-1:0] sz,
      input logic [VLW-1:0] i);
    return b + d + AW'(sz) * AW'(i);
  endfunction

  function automatic logic [AW-1:0] f_elem(input logic [AW-1:0] b,
      input logic [AW-1:0] d, input logic [VLW-1:0] i);
    return b + d * AW'(i);
  endfunction

  function automatic logic [AW-1:0] f_brev(input logic [AW-1:0] b,
      input logic [AW-1:0] d, input logic [SZW-1:0] sz,
      input logic [VLW-1:0] r, input logic [SHW-1:0] sh);
    logic [AW-1:0] off;
    off = d * AW'(sz) * AW'(r);
    return b + (off << sh);
  endfunction

  always_comb begin
    unique case (mode)
      M_ELEM:  addr = f_elem(base0, disp, idx);
      M_POST:  addr = run_base;
      M_UPD:   addr = run_next;
      M_BREV:  addr = f_brev(base0, disp, size, rev_idx, shift);
      default: addr = f_unit(base0, disp, size, idx);
    endcase
  end
endmodule

// File: rtl/vls_agen.sv
module vls_agen
  import vls_agen_pkg::*;
#(
  parameter int AW  = 64,
  parameter int DW  = 16,
  parameter int SZW = 4,
  parameter int VLW = 7,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_mode,
  input  logic           in_ra_zero,
  input  logic [AW-1:0]  in_ra_val,
  input  logic [DW-1:0]  in_disp,
  input  logic [SZW-1:0] in_size,
  input  logic [VLW-1:0] in_vl,
  input  logic [SHW-1:0] in_shift,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic [VLW-1:0] out_idx,
  output logic           out_done,
  output logic           wb_en,
  output logic [AW-1:0]  wb_base
);
  localparam int LVW = $clog2(VLW + 1);

  // named events for the checker
  logic           busy;
  logic           start_fire;
  logic           elem_fire;
  agen_mode_e     cur_mode;
  logic [AW-1:0]  cur_disp;
  logic [SZW-1:0] cur_size;

  logic [AW-1:0]  cur_base0;
  logic [SHW-1:0] cur_shift;
  logic [LVW-1:0] cur_levels;
  logic [AW-1:0]  disp_sext;
  logic [AW-1:0]  base_eff;
  agen_mode_e     mode_res;
  logic           is_last;
  logic [AW-1:0]  run_base;
  logic [AW-1:0]  run_next;
  logic [VLW-1:0] rev_idx;

  assign disp_sext  = {{(AW-DW){in_disp[DW-1]}}, in_disp};
  assign base_eff   = in_ra_zero ? '0 : in_ra_val;
  assign in_ready   = !busy;
  assign start_fire = in_valid && in_ready;
  assign out_valid  = busy;
  assign elem_fire  = out_valid && out_ready;

  // element stride with a zero displacement degenerates to unit stride
  always_comb begin
    mode_res = agen_mode_e'(in_mode);
    if (mode_res == M_ELEM && in_disp == '0) mode_res = M_UNIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur_mode   <= M_UNIT;
      cur_base0  <= '0;
      cur_disp   <= '0;
      cur_size   <= '0;
      cur_shift  <= '0;
      cur_levels <= '0;
    end else begin
      if (start_fire) begin
        busy       <= (in_vl != '0);
        cur_mode   <= mode_res;
        cur_base0  <= base_eff;
        cur_disp   <= disp_sext;
        cur_size   <= in_size;
        cur_shift  <= in_shift;
        cur_levels <= LVW'(f_levels(32'(in_vl)));
      end else if (elem_fire && is_last) begin
        busy <= 1'b0;
      end
    end
  end

  vls_agen_idx #(.VLW(VLW)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_fire),
    .step    (elem_fire),
    .vl      (in_vl),
    .idx     (out_idx),
    .is_last (is_last)
  );

  vls_agen_base #(.AW(AW)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_fire),
    .load_val (base_eff),
    .step     (elem_fire),
    .delta    (cur_disp),
    .cur      (run_base),
    .nxt      (run_next)
  );

  vls_agen_calc #(.AW(AW), .SZW(SZW), .VLW(VLW), .SHW(SHW)) u_calc (
    .mode     (cur_mode),
    .base0    (cur_base0),
    .run_base (run_base),
    .run_next (run_next),
    .disp     (cur_disp),
    .size     (cur_size),
    .idx      (out_idx),
    .levels   (cur_levels),
    .shift    (cur_shift),
    .addr     (out_addr),
    .rev_idx  (rev_idx)
  );

  assign out_done = busy && is_last;
  assign wb_en    = out_done && f_is_update(cur_mode);
  assign wb_base  = run_next;
endmodule

// File: rtl/vls_agen_chk.sv
module vls_agen_chk
  import vls_agen_pkg::*;
#(
  parameter int AW  = 64,
  parameter int SZW = 4,
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic [VLW-1:0] in_vl,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_addr,
  input logic [VLW-1:0] out_idx,
  input logic           out_done,
  input logic           wb_en,
  input logic [AW-1:0]  wb_base,
  input logic           start_fire,
  input logic           elem_fire,
  input agen_mode_e     cur_mode,
  input logic [AW-1:0]  cur_disp,
  input logic [SZW-1:0] cur_size
);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_first_elem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && in_vl != '0) |=> (out_valid && out_idx == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_idx)));

  p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_fire && !out_done) |=> (out_idx == $past(out_idx) + 1'b1));

  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_fire && !out_done && cur_mode == M_UNIT)
      |=> (out_addr == $past(out_addr) + {{(AW-SZW){1'b0}}, $past(cur_size)}));

  p_post_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_fire && !out_done && cur_mode == M_POST)
      |=> (out_addr == $past(out_addr) + $past(cur_disp)));

  p_upd_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cur_mode == M_UPD) |-> (wb_base == out_addr));

  p_vl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && in_vl == '0) |=> (in_ready && !out_valid));

  p_wb_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_done && out_valid));

  p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_fire && out_done) |=> !out_valid);
endmodule

bind vls_agen vls_agen_chk #(.AW(AW), .SZW(SZW), .VLW(VLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .in_vl      (in_vl),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_idx    (out_idx),
  .out_done   (out_done),
  .wb_en      (wb_en),
  .wb_base    (wb_base),
  .start_fire (start_fire),
  .elem_fire  (elem_fire),
  .cur_mode   (cur_mode),
  .cur_disp   (cur_disp),
  .cur_size   (cur_size)
);

// File: tb/test_vls_agen.sv
module test_vls_agen;
  localparam int AW = 64, DW = 16, SZW = 4, VLW = 7, SHW = 3;

  typedef struct packed {
    logic [2:0]     mode;
    logic           raz;
    logic [AW-1:0]  base;
    logic [DW-1:0]  disp;
    logic [SZW-1:0] size;
    logic [VLW-1:0] vl;
    logic [SHW-1:0] shift;
    logic [AW-1:0]  exp_last;
    logic           exp_wb_en;
    logic [AW-1:0]  exp_wb;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 64'h10,   16'd8,    4'd4, 7'd2, 3'd0, 64'h1C,  1'b0, 64'h0},
    '{3'd1, 1'b0, 64'h10,   16'd24,   4'd4, 7'd2, 3'd0, 64'h28,  1'b0, 64'h0},
    '{3'd2, 1'b0, 64'h10,   16'd24,   4'd4, 7'd2, 3'd0, 64'h28,  1'b1, 64'h40},
    '{3'd3, 1'b0, 64'h10,   16'd24,   4'd4, 7'd2, 3'd0, 64'h40,  1'b1, 64'h40},
    '{3'd4, 1'b0, 64'h10,   16'd1,    4'd4, 7'd4, 3'd0, 64'h1C,  1'b0, 64'h0},
    '{3'd0, 1'b1, 64'hDEAD, 16'hFFFC, 4'd8, 7'd3, 3'd0, 64'hC,   1'b0, 64'h0},
    '{3'd1, 1'b0, 64'h100,  16'd0,    4'd2, 7'd3, 3'd0, 64'h104, 1'b0, 64'h0},
    '{3'd2, 1'b0, 64'h8,    16'hFFF0, 4'd4, 7'd2, 3'd0, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 64'hFFFF_FFFF_FFFF_FFE8},
    '{3'd4, 1'b0, 64'h0,    16'd2,    4'd4, 7'd8, 3'd2, 64'hE0,  1'b0, 64'h0},
    '{3'd3, 1'b1, 64'h999,  16'h10,   4'd4, 7'd4, 3'd0, 64'h40,  1'b1, 64'h40},
    '{3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 16'd0, 4'd8, 7'd3, 3'd0, 64'h0, 1'b0, 64'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_mode = '0;
  logic in_ra_zero = 1'b0;
  logic [AW-1:0] in_ra_val = '0;
  logic [DW-1:0] in_disp = '0;
  logic [SZW-1:0] in_size = '0;
  logic [VLW-1:0] in_vl = '0;
  logic [SHW-1:0] in_shift = '0;
  logic out_valid, out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [VLW-1:0] out_idx;
  logic out_done, wb_en;
  logic [AW-1:0] wb_base;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  vls_agen i_vls_agen (.*);

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0, 10:   return "R1_R7";
      1:       return "R2";
      6:       return "R2_zero_disp";
      2:       return "R4";
      7:       return "R4_R7";
      3:       return "R5";
      9:       return "R5_R3";
      5:       return "R3_R7";
      default: return "R6";
    endcase
  endfunction

  // independent reference: iterate instead of multiplying
  function automatic logic [AW-1:0] model(input vec_t v, input int i);
    logic [AW-1:0] b, d, acc;
    int lv, r, m;
    b = v.raz ? 64'd0 : v.base;
    d = {{(AW-DW){v.disp[DW-1]}}, v.disp};
    m = int'(v.mode);
    if (m == 1 && v.disp == 0) m = 0;
    acc = 0;
    case (m)
      1: begin for (int k = 0; k < i; k++) acc += d; return b + acc; end
      2: begin for (int k = 0; k < i; k++) acc += d; return b + acc; end
      3: begin for (int k = 0; k <= i; k++) acc += d; return b + acc; end
      4: begin
        lv = 0;
        while ((1 << lv) < int'(v.vl)) lv++;
        r = 0;
        for (int k = 0; k < lv; k++) r = (r << 1) | ((i >> k) & 1);
        for (int k = 0; k < r * int'(v.size); k++) acc += d;
        return b + (acc << v.shift);
      end
      default: begin
        for (int k = 0; k < i; k++) acc += 64'(v.size);
        return b + d + acc;
      end
    endcase
  endfunction

  task automatic drive(input vec_t v);
    in_mode = v.mode; in_ra_zero = v.raz; in_ra_val = v.base;
    in_disp = v.disp; in_size = v.size; in_vl = v.vl; in_shift = v.shift;
  endtask

  task automatic run_vec(input int k);
    vec_t v;
    string t;
    v = VECS[k];
    t = tag_of(k);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < int'(v.vl); i++) begin
      chk(out_addr == model(v, i), t, out_addr, model(v, i));
      chk(out_valid && out_idx == VLW'(i), "R10", 64'(out_idx), 64'(i));
      chk(out_done == (i == int'(v.vl) - 1), "R11", 64'(out_done), 64'(i == int'(v.vl) - 1));
      if (i == int'(v.vl) - 1) begin
        chk(out_addr == v.exp_last, t, out_addr, v.exp_last);
        chk(wb_en == v.exp_wb_en, "R11", 64'(wb_en), 64'(v.exp_wb_en));
        if (v.exp_wb_en) chk(wb_base == v.exp_wb, t, wb_base, v.exp_wb);
      end else begin
        chk(!wb_en, "R11", 64'(wb_en), 64'd0);
      end
      @(negedge clk);
    end
    chk(!out_valid && in_ready, "R11", 64'(out_valid), 64'd0);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // reset state
    chk(in_ready && !out_valid && !wb_en, "R9", {61'd0, in_ready, out_valid, wb_en}, 64'h4);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(k);

    // R8: zero-length request
    @(negedge clk);
    v = VECS[2];
    v.vl = '0;
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid && in_ready && !wb_en, "R8", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk(!out_valid, "R8", 64'(out_valid), 64'd0);

    // R9/R10: backpressure and request while busy
    out_ready = 1'b0;
    v = VECS[0];
    v.base = 64'h100; v.disp = 16'd0; v.vl = 7'd2;
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R9", 64'(in_ready), 64'd0);
    chk(out_addr == 64'h100 && out_idx == 0, "R10", out_addr, 64'h100);
    in_ra_val = 64'h900; in_vl = 7'd5;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid && out_addr == 64'h100 && out_idx == 0, "R10", out_addr, 64'h100);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_addr == 64'h104 && out_done, "R9", out_addr, 64'h104);
    @(negedge clk);
    chk(!out_valid && in_ready, "R9", 64'(out_valid), 64'd0);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule